// File: doc/BRIEF.md
# Stall-Guarded Memory-Mapped Bus Master

This block is the master-side front end between an internal requester and a memory-mapped bus whose slaves can stall a transfer. The requester hands over one command at a time, a read or a write with an address and, for writes, data. The block registers that command onto the bus strobes one cycle later. It keeps the strobes up until the bus stops stalling, then reports completion to the requester. For a read, it also captures the returned data.

Every register that faces the bus sits under one guard: on any edge where the stall input is high, nothing updates. That covers the read and write strobes, the address, the write data and the sequencing state. Because of this single guard, no individual state has to remember to test the stall. A command can be taken on the same edge as the completion of the previous one, so transfers can run back to back with no idle cycle.

Top module: `mmr_req_hold`

## Requirements
- R1: While `rst` is high at a clock edge, `bus_rd`, `bus_wr` and `rsp_done` are low after that edge.
- R2: On an edge where `bus_stall` is high, `bus_rd`, `bus_wr`, `bus_addr` and `bus_wdata` keep the values they had before the edge.
- R3: A command is taken only on an edge where `cmd_valid` is high and `bus_stall` is low. From the next cycle, the bus shows `bus_rd` = 1 if `cmd_we` was 0, or `bus_wr` = 1 if `cmd_we` was 1, together with that command's address and data. This is one cycle of latency.
- R4: `cmd_ready` is high exactly in cycles where `bus_stall` is low. It is high when no transfer is outstanding, or when the outstanding one is completing on this edge.
- R5: A read completes on the first edge where `bus_rd` is high and `bus_stall` is low. On that edge, `rsp_rdata` captures `bus_rdata`, and `rsp_done` is high for the following cycle only.
- R6: A write completes on the first edge where `bus_wr` is high and `bus_stall` is low. `rsp_done` then pulses for one cycle, and `rsp_rdata` is left unchanged.
- R7: On a completion edge with no command offered, `bus_rd` and `bus_wr` drop low. If a command is offered on that edge, it is presented in the very next cycle with no idle gap.
- R8: `bus_rd` and `bus_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Requester offers a command |
| cmd_ready | output | 1 | Command is taken on this edge if valid |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Command write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Data captured by the last completed read |
| bus_rd | output | 1 | Read strobe toward the bus |
| bus_wr | output | 1 | Write strobe toward the bus |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data |
| bus_stall | input | 1 | Slave stall; high freezes the request |

## Verification
The first pattern is a single read and a single write with no stall. It separates a correct one-cycle presentation latency from an extra or a missing register stage. The second pattern stretches reads and writes with several stall cycles. It shows whether the strobes, address and data stay frozen, and whether the captured data comes from the releasing cycle and not an earlier one. The third pattern offers a command while idle under stall, and it must not be taken. The fourth pattern issues commands back to back, which exposes a lost or doubled command at the completion edge. A long pseudo-random run then mixes stalls, command types and a mid-transfer reset, and the bench compares it against a behavioural model on every cycle.

// File: rtl/mmr_pkg.sv
package mmr_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } mmr_state_e;
endpackage

// File: rtl/mmr_cmd_fsm.sv
module mmr_cmd_fsm
  import mmr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              cmd_valid,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              xfer_end,
  output logic              xfer_rd
);
  mmr_state_e state;
  logic       advance;
  logic       take;

  // The single guard: nothing bus-facing moves unless the slave is not stalling.
  assign advance   = !stall;
  assign cmd_ready = advance;
  assign take      = advance && cmd_valid;
  assign xfer_end  = (state == ST_BUSY) && advance;
  assign xfer_rd   = bus_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (advance) begin
      if (take) begin
        state     <= ST_BUSY;
        bus_rd    <= !cmd_we;
        bus_wr    <= cmd_we;
        bus_addr  <= cmd_addr;
        bus_wdata <= cmd_wdata;
      end else begin
        state  <= ST_IDLE;
        bus_rd <= 1'b0;
        bus_wr <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mmr_rdata_cap.sv
module mmr_rdata_cap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_end,
  input  logic              xfer_rd,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= xfer_end;
      if (xfer_end && xfer_rd) rsp_rdata <= bus_rdata;
    end
  end
endmodule

// File: rtl/mmr_req_hold.sv
module mmr_req_hold #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_stall
);
  logic xfer_end;
  logic xfer_rd;

  mmr_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .stall     (bus_stall),
    .cmd_valid (cmd_valid),
    .cmd_we    (cmd_we),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_ready (cmd_ready),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .xfer_end  (xfer_end),
    .xfer_rd   (xfer_rd)
  );

  mmr_rdata_cap #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .xfer_end  (xfer_end),
    .xfer_rd   (xfer_rd),
    .bus_rdata (bus_rdata),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/mmr_req_hold_chk.sv
module mmr_req_hold_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_done,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_stall
);
  logic rst_seen;
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q    <= rst;
    rst_seen <= rst_seen | rst;
  end

  always @(negedge clk) begin
    if (rst_seen === 1'b1 && rst_q === 1'b1)
      AST_RST_QUIET: assert (!bus_rd && !bus_wr && !rsp_done); // R1
  end

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    bus_stall |=> ($stable(bus_rd) && $stable(bus_wr) && $stable(bus_addr) && $stable(bus_wdata))); // R2

  AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (bus_rd || bus_wr)); // R3

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && !bus_stall) |=> rsp_done); // R5

  AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (rst)
    (!(bus_rd || bus_wr) || bus_stall) |=> !rsp_done); // R6

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr)); // R8
endmodule

bind mmr_req_hold mmr_req_hold_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .rsp_done  (rsp_done),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_stall (bus_stall)
);

// File: tb/mmr_req_hold_tb.sv
module mmr_req_hold_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_we = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic          bus_rd, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_stall = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  mmr_req_hold #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_stall(bus_stall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: one pending transfer, held in integers.
  int m_kind = 0;            // 0 none, 1 read, 2 write
  longint m_addr = 0, m_wdata = 0, m_rdata = 0;
  bit m_done = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_kind = 0; m_addr = 0; m_wdata = 0; m_rdata = 0; m_done = 0;
    end else begin
      m_done = (m_kind != 0) && !bus_stall;
      if (m_done && m_kind == 1) m_rdata = bus_rdata;
      if (!bus_stall) begin
        if (cmd_valid) begin
          m_kind = cmd_we ? 2 : 1;
          m_addr = cmd_addr;
          m_wdata = cmd_wdata;
        end else begin
          m_kind = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(bus_rd == (m_kind == 1), "R3 bus_rd", bus_rd, m_kind == 1);
    chk(bus_wr == (m_kind == 2), "R3 bus_wr", bus_wr, m_kind == 2);
    if (m_kind != 0) begin
      chk(bus_addr == AW'(m_addr), "R2 bus_addr", bus_addr, m_addr);
      if (m_kind == 2) chk(bus_wdata == DW'(m_wdata), "R2 bus_wdata", bus_wdata, m_wdata);
    end
    chk(rsp_done == m_done, "R5 rsp_done", rsp_done, m_done);
    chk(rsp_rdata == DW'(m_rdata), "R5 rsp_rdata", rsp_rdata, m_rdata);
    chk(cmd_ready == !bus_stall, "R4 cmd_ready", cmd_ready, !bus_stall);
    chk(!(bus_rd && bus_wr), "R8 one strobe", {bus_rd, bus_wr}, 0);
  endtask

  logic [DW-1:0] pat = 32'h1234_5678;

  task automatic step(input bit v, input bit we, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input bit st);
    @(negedge clk);
    compare_all();
    cmd_valid = v; cmd_we = we; cmd_addr = a; cmd_wdata = d; bus_stall = st;
    pat = {pat[30:0], pat[31] ^ pat[21] ^ pat[1] ^ pat[0]};
    bus_rdata = pat;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  logic [DW-1:0] saved;
  logic [AW-1:0] lfsr = 16'hACE1;

  initial begin
    repeat (3) step(1, 1, 16'h5555, 32'hFFFF_FFFF, 0);
    @(negedge clk);
    chk(!bus_rd && !bus_wr && !rsp_done, "R1 reset quiet", {bus_rd, bus_wr, rsp_done}, 0);
    rst = 1'b0;
    cmd_valid = 0;

    // single read, no stall
    step(1, 0, 16'h0010, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    chk(bus_rd == 0 && rsp_done == 1, "R7 idle after read", {bus_rd, rsp_done}, 1);

    // read stretched by stalls
    step(1, 0, 16'h0020, 0, 0);
    step(0, 0, 16'hFFFF, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    @(negedge clk);
    chk(bus_addr == 16'h0020 && bus_rd, "R2 held under stall", bus_addr, 16'h0020);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    // write with stall; rdata untouched
    saved = rsp_rdata;
    step(1, 1, 16'h0030, 32'hCAFE_0001, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    chk(rsp_rdata == saved, "R6 rdata kept on write", rsp_rdata, saved);

    // offered while idle under stall: not taken
    step(1, 1, 16'h0040, 32'h1, 1);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    chk(!bus_wr && !bus_rd, "R3 not taken under stall", {bus_rd, bus_wr}, 0);

    // back to back read then write
    step(1, 0, 16'h0050, 0, 0);
    step(1, 1, 16'h0051, 32'hBEEF_0002, 0);
    @(negedge clk);
    chk(bus_wr && bus_addr == 16'h0051, "R7 back to back", {bus_wr, bus_addr}, {1'b1, 16'h0051});
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    // mixed pseudo-random run with a mid-run reset
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i == 300) rst = 1'b1;
      if (i == 302) rst = 1'b0;
      step(lfsr[0] | lfsr[3], lfsr[1], lfsr, {lfsr, ~lfsr}, lfsr[2] & lfsr[5]);
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule